// File: doc/BRIEF.md
# Clock-group frequency scaling controller

This block changes the division ratios of four clock groups while the chip keeps running. Every group runs from one fast source clock through its own programmable integer divider. The divider produces a one-cycle clock-enable pulse per period. A scaling request carries a new divisor code for every group and starts with a single-cycle trigger.

The controller checks whether the request keeps the relationship between the groups intact. A request is uniform when every new divisor is the old divisor times one common integer factor. Such a request is applied directly, with each divider switching at its own period boundary. Any other request changes the ratios between groups. In that case the controller first raises a halt request toward the system and waits until the system acknowledges it. Only then are the new divisors loaded. The halt is held until every group runs at its new ratio and one further period of the slowest new group has passed. A trigger that arrives while a change is in progress is dropped and leaves a sticky error flag.

Top module: `fscale_ctrl`

## Requirements
- R1: After reset `halt_req_o`, `busy_o`, `done_o` and `err_o` are low, and every group divides by 1, so all bits of `grp_en_o` are high on every cycle.
- R2: Group g takes its divisor code from `new_div_i[4g+3:4g]`, and code c means divide by c+1 (1 to 16). Once a request completes, `grp_en_o[g]` pulses high for one cycle in every c+1 cycles.
- R3: A divisor change takes effect only at a period boundary. Every interval between two enable pulses of a group equals either the old or the new period, never anything shorter or in between.
- R4: If some integer k ≥ 1 exists with new divisor = k × current divisor for all four groups, the request is uniform. `halt_req_o` stays low for the whole request, while `busy_o` is high until completion.
- R5: A request that is not uniform raises `halt_req_o` in the first cycle after the trigger is sampled. The group periods stay unchanged while no acknowledge has been seen.
- R6: `halt_req_o` stays high until `halt_ack_i` has been sampled high, and no new divisor is loaded before that.
- R7: After the acknowledge, `halt_req_o` stays high until all groups run at their new divisors and one further full period of the slowest new group has passed. It falls in the same cycle as the `done_o` pulse.
- R8: A trigger sampled while `busy_o` is high is ignored and has no effect on the divisors. It sets `err_o`, which stays high until reset.
- R9: `done_o` is a one-cycle pulse that marks completion. `busy_o` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock shared by all dividers |
| rst_n | input | 1 | Active-low synchronous reset |
| trigger_i | input | 1 | One-cycle start of a scaling request |
| new_div_i | input | 16 | Four 4-bit divisor codes, group g at bits 4g+3:4g, value code+1 |
| halt_ack_i | input | 1 | System acknowledge of the halt request |
| halt_req_o | output | 1 | Halt request toward the system |
| busy_o | output | 1 | A scaling request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky flag: a trigger arrived while busy |
| grp_en_o | output | 4 | Per-group clock-enable pulses, one per divided period |

## Verification
A corrupted divider count or divisor appears at the port as an enable interval of the wrong length. The pulse-spacing monitor catches it within one slowest period, at most 16 cycles. A misclassified request shows up in the cycle after the trigger, because the halt request is then present where it should be absent, or the reverse. A sequencer that leaves its wait state too early drops the halt before the settle window has passed, which the bench sees as a too-short interval from acknowledge to done. Ratio changes in both directions are exercised, along with a factor of one, a late acknowledge and a trigger that arrives while busy.

// File: rtl/fscale_pkg.sv
package fscale_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_APPLY,
        ST_SETTLE
    } seq_state_e;

endpackage

// File: rtl/fscale_divider.sv
module fscale_divider #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              en_o,
    output logic              pend_o,
    output logic [CODE_W-1:0] div_o
);

    typedef struct packed {
        logic [CODE_W-1:0] cnt;
        logic [CODE_W-1:0] div;
        logic [CODE_W-1:0] pdiv;
        logic              pend;
    } div_state_t;

    div_state_t q, d;
    logic       boundary;
    logic       pend_now;

    assign boundary = (q.cnt == q.div);
    assign pend_now = load_i | q.pend;

    always_comb begin
        d      = q;
        d.pend = pend_now;
        if (load_i) begin
            d.pdiv = code_i;
        end
        if (boundary) begin
            d.cnt = '0;
            if (pend_now) begin
                d.div  = load_i ? code_i : q.pdiv;
                d.pend = 1'b0;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign en_o   = boundary;
    assign pend_o = q.pend;
    assign div_o  = q.div;

    // R3: the divisor register moves only when the period ends
    p_div_at_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != q.div) |=> (q.div == $past(q.div)));

    // R2: the counter never runs past the active divisor
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= q.div);

endmodule

// File: rtl/fscale_ratio_check.sv
module fscale_ratio_check #(
    parameter int NUM_GRP = 4,
    parameter int CODE_W  = 4
) (
    input  logic [NUM_GRP-1:0][CODE_W-1:0] cur_i,
    input  logic [NUM_GRP-1:0][CODE_W-1:0] nxt_i,
    output logic                           uniform_o,
    output logic [CODE_W-1:0]              max_o
);

    localparam int MAX_K = 1 << CODE_W;
    localparam int PW    = 2 * CODE_W + 2;
    localparam logic [PW-1:0] ONE = PW'(1);

    logic          all_match;
    logic [PW-1:0] cur_val;
    logic [PW-1:0] nxt_val;
    logic [PW-1:0] prod;

    // uniform when one integer factor maps every current divisor to its new one
    always_comb begin
        uniform_o = 1'b0;
        all_match = 1'b0;
        cur_val   = '0;
        nxt_val   = '0;
        prod      = '0;
        for (int k = 1; k <= MAX_K; k++) begin
            all_match = 1'b1;
            for (int g = 0; g < NUM_GRP; g++) begin
                cur_val = PW'(cur_i[g]) + ONE;
                nxt_val = PW'(nxt_i[g]) + ONE;
                prod    = cur_val * PW'(k);
                if (prod != nxt_val) begin
                    all_match = 1'b0;
                end
            end
            if (all_match) begin
                uniform_o = 1'b1;
            end
        end
    end

    always_comb begin
        max_o = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (nxt_i[g] > max_o) begin
                max_o = nxt_i[g];
            end
        end
    end

endmodule

// File: rtl/fscale_sequencer.sv
module fscale_sequencer
    import fscale_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int CODE_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           trigger_i,
    input  logic [NUM_GRP-1:0][CODE_W-1:0] req_codes_i,
    input  logic                           uniform_i,
    input  logic [CODE_W-1:0]              max_code_i,
    input  logic                           halt_ack_i,
    input  logic                           any_pend_i,
    output logic                           load_o,
    output logic [NUM_GRP-1:0][CODE_W-1:0] nxt_codes_o,
    output logic                           halt_o,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           err_o
);

    typedef struct packed {
        seq_state_e                     st;
        logic [NUM_GRP-1:0][CODE_W-1:0] nxt;
        logic [CODE_W-1:0]              cnt;
        logic [CODE_W-1:0]              smax;
        logic                           load;
        logic                           halt;
        logic                           done;
        logic                           err;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.load = 1'b0;
        d.done = 1'b0;
        if (trigger_i && (q.st != ST_IDLE)) begin
            d.err = 1'b1;
        end
        case (q.st)
            ST_IDLE: begin
                if (trigger_i) begin
                    d.nxt  = req_codes_i;
                    d.smax = max_code_i;
                    if (uniform_i) begin
                        d.st   = ST_APPLY;
                        d.load = 1'b1;
                    end else begin
                        d.st   = ST_REQ;
                        d.halt = 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (halt_ack_i) begin
                    d.load = 1'b1;
                    d.st   = ST_APPLY;
                end
            end
            ST_APPLY: begin
                if (!q.load && !any_pend_i) begin
                    if (q.halt) begin
                        d.st  = ST_SETTLE;
                        d.cnt = '0;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (q.cnt == q.smax) begin
                    d.halt = 1'b0;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign load_o      = q.load;
    assign nxt_codes_o = q.nxt;
    assign halt_o      = q.halt;
    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = q.done;
    assign err_o       = q.err;

    // R6: request held while the acknowledge is absent
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_REQ && !halt_ack_i) |=> q.halt);

    // R6: nothing is loaded ahead of the acknowledge
    p_no_early_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_REQ && !halt_ack_i) |=> !q.load);

    // R4: uniform requests never halt the system
    p_uniform_no_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && trigger_i && uniform_i) |=> !q.halt);

    // R7: the halt drops only together with completion
    p_halt_fall_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.halt) |-> q.done);

    // R9: completion lasts one cycle and coincides with idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.st == ST_IDLE));

    // R8: error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err);

endmodule

// File: rtl/fscale_ctrl.sv
module fscale_ctrl #(
    parameter int NUM_GRP = 4,
    parameter int CODE_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trigger_i,
    input  logic [NUM_GRP*CODE_W-1:0] new_div_i,
    input  logic                      halt_ack_i,
    output logic                      halt_req_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      err_o,
    output logic [NUM_GRP-1:0]        grp_en_o
);

    logic [NUM_GRP-1:0][CODE_W-1:0] req_codes;
    logic [NUM_GRP-1:0][CODE_W-1:0] cur_codes;
    logic [NUM_GRP-1:0][CODE_W-1:0] nxt_codes;
    logic [NUM_GRP-1:0]             pend;
    logic                           uniform;
    logic [CODE_W-1:0]              max_code;
    logic                           load;

    assign req_codes = new_div_i;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        fscale_divider #(.CODE_W(CODE_W)) i_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .code_i (nxt_codes[g]),
            .en_o   (grp_en_o[g]),
            .pend_o (pend[g]),
            .div_o  (cur_codes[g])
        );
    end

    fscale_ratio_check #(.NUM_GRP(NUM_GRP), .CODE_W(CODE_W)) i_ratio (
        .cur_i     (cur_codes),
        .nxt_i     (req_codes),
        .uniform_o (uniform),
        .max_o     (max_code)
    );

    fscale_sequencer #(.NUM_GRP(NUM_GRP), .CODE_W(CODE_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger_i   (trigger_i),
        .req_codes_i (req_codes),
        .uniform_i   (uniform),
        .max_code_i  (max_code),
        .halt_ack_i  (halt_ack_i),
        .any_pend_i  (|pend),
        .load_o      (load),
        .nxt_codes_o (nxt_codes),
        .halt_o      (halt_req_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

endmodule

// File: tb/test_fscale_ctrl.sv
`timescale 1ns/1ps
module test_fscale_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trigger = 1'b0;
    logic [15:0] new_div = '0;
    logic        ack = 1'b0;
    logic        halt_req, busy, done, err;
    logic [3:0]  en;

    int n_chk = 0;
    int n_fail = 0;
    int allow_a [4];
    int allow_b [4];
    int since [4];
    bit seen [4];
    int runt_bad = 0;

    always #5 clk = ~clk;

    fscale_ctrl i_fscale_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trigger_i  (trigger),
        .new_div_i  (new_div),
        .halt_ack_i (ack),
        .halt_req_o (halt_req),
        .busy_o     (busy),
        .done_o     (done),
        .err_o      (err),
        .grp_en_o   (en)
    );

    // R3 monitor: every pulse interval must be the old or the new period
    always @(negedge clk) begin
        if (rst_n) begin
            for (int g = 0; g < 4; g++) begin
                if (en[g]) begin
                    if (seen[g] && (since[g] + 1 != allow_a[g]) && (since[g] + 1 != allow_b[g]))
                        runt_bad++;
                    seen[g]  = 1'b1;
                    since[g] = 0;
                end else begin
                    since[g]++;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pack(input int nd [4]);
        logic [15:0] r = '0;
        for (int g = 0; g < 4; g++) r[g*4 +: 4] = 4'(nd[g] - 1);
        return r;
    endfunction

    task automatic measure_gap(input int g, output int gap);
        @(negedge clk);
        while (!en[g]) @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!en[g]);
    endtask

    task automatic check_periods(input int nd [4], input string tag);
        int gap;
        for (int g = 0; g < 4; g++) begin
            measure_gap(g, gap);
            chk("R2", $sformatf("%s period of group %0d", tag, g), gap, nd[g]);
        end
        chk("R3", {tag, " intervals outside old/new period"}, runt_bad, 0);
        for (int g = 0; g < 4; g++) allow_a[g] = nd[g];
    endtask

    task automatic t_reset();
        chk("R1", "halt_req after reset", int'(halt_req), 0);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "err after reset", int'(err), 0);
        for (int i = 0; i < 3; i++) begin
            chk("R1", "enables at divide-by-1", int'(en), 15);
            @(negedge clk);
        end
    endtask

    task automatic t_uniform(input int nd [4], input string tag);
        int halt_bad = 0;
        int cyc = 0;
        for (int g = 0; g < 4; g++) allow_b[g] = nd[g];
        new_div = pack(nd);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        chk("R4", {tag, " busy after trigger"}, int'(busy), 1);
        while (!done && cyc < 200) begin
            if (halt_req) halt_bad++;
            @(negedge clk);
            cyc++;
        end
        chk("R4", {tag, " halt_req cycles"}, halt_bad + int'(halt_req), 0);
        chk("R9", {tag, " done seen"}, int'(done), 1);
        chk("R9", {tag, " busy at done"}, int'(busy), 0);
        @(negedge clk);
        chk("R9", {tag, " done single cycle"}, int'(done), 0);
        check_periods(nd, tag);
    endtask

    task automatic t_nonuniform(input int nd [4], input int late, input bit extra, input string tag);
        int gap;
        int cyc = 0;
        int halt_bad = 0;
        int maxd = 0;
        int other [4] = '{1, 1, 1, 1};
        for (int g = 0; g < 4; g++) begin
            allow_b[g] = nd[g];
            if (nd[g] > maxd) maxd = nd[g];
        end
        new_div = pack(nd);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        chk("R5", {tag, " halt_req after trigger"}, int'(halt_req), 1);
        chk("R5", {tag, " busy after trigger"}, int'(busy), 1);
        if (extra) begin
            new_div = pack(other);
            trigger = 1'b1;
            @(negedge clk);
            trigger = 1'b0;
            @(negedge clk);
            chk("R8", {tag, " err after busy trigger"}, int'(err), 1);
            chk("R8", {tag, " still waiting for ack"}, int'(halt_req), 1);
        end
        measure_gap(3, gap);
        chk("R5", {tag, " slowest period unchanged before ack"}, gap, allow_a[3]);
        for (int i = 0; i < late; i++) begin
            if (!halt_req) halt_bad++;
            @(negedge clk);
        end
        chk("R6", {tag, " halt_req dropped without ack"}, halt_bad + int'(!halt_req), 0);
        ack = 1'b1;
        halt_bad = 0;
        while (cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (done) break;
            if (!halt_req) halt_bad++;
        end
        chk("R7", {tag, " halt_req low before done"}, halt_bad, 0);
        chk("R7", {tag, " halt_req falls with done"}, int'(halt_req), 0);
        chk("R7", {tag, " settle window respected"}, int'(cyc >= maxd + 1), 1);
        chk("R9", {tag, " busy at done"}, int'(busy), 0);
        ack = 1'b0;
        @(negedge clk);
        chk("R9", {tag, " done single cycle"}, int'(done), 0);
        check_periods(nd, tag);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL all watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int g = 0; g < 4; g++) begin
            allow_a[g] = 1;
            allow_b[g] = 1;
            since[g]   = 0;
            seen[g]    = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nonuniform('{1, 2, 3, 4}, 5, 1'b0, "ratio change from reset");
        chk("R8", "err clear without busy trigger", int'(err), 0);
        t_uniform('{2, 4, 6, 8}, "uniform factor 2");
        t_uniform('{4, 8, 12, 16}, "uniform factor 2 again");
        t_uniform('{4, 8, 12, 16}, "uniform factor 1");
        t_nonuniform('{4, 8, 6, 16}, 20, 1'b1, "one group changed plus busy trigger");
        t_nonuniform('{2, 4, 6, 8}, 3, 1'b0, "faster non-integer factor");
        chk("R8", "err sticky after later requests", int'(err), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule